// File: doc/BRIEF.md
# Multiplexed Bus Cycle Controller

This block is a bus master sequencer that carries out one memory or I/O transfer for each request it receives. Address and data share a single set of bus lines, separated in time: the address goes out in the first clock state, and the transfer itself runs in the states after it. A basic transfer takes four clock states, T1 to T4. A slow target can stretch a transfer by holding its ready line low, which inserts any number of wait states between T2 and T4.

On the request side, a client pulses `start` together with an address, write data, a write flag and an I/O flag. In T4 it gets a one-cycle `rsp_done` pulse, and for a read the captured data appears on `rsp_rdata` in the same cycle. On the bus side the block drives the shared lines through an output-enable. It also drives an address strobe, a direction line, a memory/I/O select, active-low read and write strobes and an active-low transceiver enable. A request made in T4 starts the next transfer without an idle cycle in between.

Top module: `muxbus_master`

## Requirements
- R1: During and after reset, with no request, the block sits idle. In idle `bus_ad_oe` = 0, `bus_ale` = 0, `rsp_done` = 0, and `bus_rd_n`, `bus_wr_n` and `bus_den_n` are all 1.
- R2: When `start` is high at a clock edge while the block is idle, the next cycle is T1. In T1, `bus_ale` = 1 for exactly that one cycle and `bus_ad_oe` = 1. `bus_ad_out` carries `req_addr`, zero-extended to the bus width. `bus_dt_r` equals the write flag (1 = write, 0 = read) and `bus_io_sel` equals the I/O flag (1 = I/O, 0 = memory). Both hold until the next T1.
- R3: In a read, `bus_rd_n` = 0 in T2, in every wait state and in T3. `bus_wr_n` stays 1 throughout. `bus_ad_oe` = 0 from T2 through T4, so the bus is released to the target.
- R4: In a write, `bus_wr_n` = 0 in T2, in every wait state and in T3. `bus_rd_n` stays 1 throughout. From T2 onward, `bus_ad_oe` = 1 and `bus_ad_out` carries `req_wdata`.
- R5: `bus_den_n` = 0 in T2, in every wait state and in T3, for both reads and writes. It is 1 in T1, in T4 and in idle.
- R6: `bus_ready` is sampled at the end of T2 and at the end of each wait state. A low sample leads to a further wait state and a high sample leads to T3. A transfer with N low samples therefore lasts 4 + N cycles.
- R7: In a read, `bus_ad_in` is captured at the end of T3 and shown on `rsp_rdata` in T4, while `rsp_done` = 1 for that single cycle. `rsp_rdata` then holds its value until the next read, and writes leave it unchanged.
- R8: In T4, `bus_rd_n`, `bus_wr_n` and `bus_den_n` are 1 and `bus_ale` = 0. In a write, the data stays driven on the bus through T4, so the rising edge of the write strobe occurs while the data is still valid.
- R9: A request is taken only in idle or in T4. A `start` in T4 makes the next cycle T1, with no idle cycle in between. A `start` in T1, T2, a wait state or T3 is ignored: the running transfer keeps its address and data, and no extra transfer follows.
- R10: `bus_ready` has no effect in T1, T3 or T4. T3 is always followed by T4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request strobe |
| req_addr | input | AW | Transfer address |
| req_wdata | input | DW | Data for a write |
| req_write | input | 1 | 1 = write, 0 = read |
| req_io | input | 1 | 1 = I/O space, 0 = memory |
| rsp_rdata | output | DW | Captured read data |
| rsp_done | output | 1 | One-cycle completion pulse in T4 |
| bus_ad_out | output | BW | Value driven onto the shared address/data lines |
| bus_ad_oe | output | 1 | Output enable for the shared lines |
| bus_ad_in | input | BW | Value seen on the shared lines |
| bus_ale | output | 1 | Address strobe, high in T1 |
| bus_dt_r | output | 1 | Direction, 1 = transmit (write) |
| bus_io_sel | output | 1 | 1 = I/O, 0 = memory |
| bus_rd_n | output | 1 | Read strobe, active low |
| bus_wr_n | output | 1 | Write strobe, active low |
| bus_den_n | output | 1 | Transceiver enable, active low |
| bus_ready | input | 1 | Target ready, sampled at the end of T2 and of each wait state |

## Verification
A target model in the bench answers each transfer, and transfers are queued in mixed patterns. These include reads and writes to memory and to I/O with zero, one, a few and many wait states, which show whether the ready line is sampled at the right points and whether each extra cycle is exactly one wait state. The target drives the read value only during T3 and garbage otherwise, so capture one cycle early or late shows up as wrong data. It also holds ready low in T1, T3 and T4 on some transfers, which separates true sampling points from ignored ones. A back-to-back write/read pair, and a request held high in the middle of a long write, show whether requests are taken only in idle or T4.

// File: rtl/muxbus_pkg.sv
`timescale 1ns/1ps
package muxbus_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_T1   = 3'd1,
        ST_T2   = 3'd2,
        ST_TW   = 3'd3,
        ST_T3   = 3'd4,
        ST_T4   = 3'd5
    } bus_state_e;

endpackage

// File: rtl/muxbus_seq.sv
`timescale 1ns/1ps
module muxbus_seq
    import muxbus_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    input  logic          req_write,
    input  logic          req_io,
    input  logic          ready,
    output bus_state_e    state,
    output logic [AW-1:0] lat_addr,
    output logic [DW-1:0] lat_wdata,
    output logic          lat_write,
    output logic          lat_io
);

    typedef struct packed {
        bus_state_e    st;
        logic [AW-1:0] addr;
        logic [DW-1:0] wdata;
        logic          wr;
        logic          io;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d = seq_q;
        case (seq_q.st)
            ST_IDLE, ST_T4: begin
                if (start) begin
                    seq_d.st    = ST_T1;
                    seq_d.addr  = req_addr;
                    seq_d.wdata = req_wdata;
                    seq_d.wr    = req_write;
                    seq_d.io    = req_io;
                end else begin
                    seq_d.st = ST_IDLE;
                end
            end
            ST_T1:        seq_d.st = ST_T2;
            ST_T2, ST_TW: seq_d.st = ready ? ST_T3 : ST_TW;
            ST_T3:        seq_d.st = ST_T4;
            default:      seq_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '{st: ST_IDLE, addr: '0, wdata: '0, wr: 1'b0, io: 1'b0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign state     = seq_q.st;
    assign lat_addr  = seq_q.addr;
    assign lat_wdata = seq_q.wdata;
    assign lat_write = seq_q.wr;
    assign lat_io    = seq_q.io;

    assert_t1_then_t2_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.st == ST_T1) |=> (seq_q.st == ST_T2));

    assert_wait_insert_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((seq_q.st == ST_T2 || seq_q.st == ST_TW) && !ready) |=> (seq_q.st == ST_TW));

    assert_wait_exit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((seq_q.st == ST_T2 || seq_q.st == ST_TW) && ready) |=> (seq_q.st == ST_T3));

    assert_t3_then_t4_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.st == ST_T3) |=> (seq_q.st == ST_T4));

    assert_req_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.st inside {ST_T1, ST_T2, ST_TW, ST_T3})
        |=> ($stable(seq_q.addr) && $stable(seq_q.wdata) && $stable(seq_q.wr)));

endmodule

// File: rtl/muxbus_pins.sv
`timescale 1ns/1ps
module muxbus_pins
    import muxbus_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 16,
    parameter int BW = 16
) (
    input  bus_state_e    state,
    input  logic [AW-1:0] lat_addr,
    input  logic [DW-1:0] lat_wdata,
    input  logic          lat_write,
    input  logic          lat_io,
    output logic [BW-1:0] ad_out,
    output logic          ad_oe,
    output logic          ale,
    output logic          dt_r,
    output logic          io_sel,
    output logic          rd_n,
    output logic          wr_n,
    output logic          den_n
);

    logic [BW-1:0] addr_ext;
    logic [BW-1:0] data_ext;
    logic          strobe_ph;
    logic          data_ph;

    generate
        if (AW < BW) begin : g_addr_pad
            assign addr_ext = {{(BW-AW){1'b0}}, lat_addr};
        end else begin : g_addr_full
            assign addr_ext = lat_addr;
        end
        if (DW < BW) begin : g_data_pad
            assign data_ext = {{(BW-DW){1'b0}}, lat_wdata};
        end else begin : g_data_full
            assign data_ext = lat_wdata;
        end
    endgenerate

    always_comb begin
        strobe_ph = (state == ST_T2) || (state == ST_TW) || (state == ST_T3);
        data_ph   = lat_write && (strobe_ph || (state == ST_T4));
        ale       = (state == ST_T1);
        ad_oe     = (state == ST_T1) || data_ph;
        if (state == ST_T1) begin
            ad_out = addr_ext;
        end else if (data_ph) begin
            ad_out = data_ext;
        end else begin
            ad_out = '0;
        end
        dt_r   = lat_write;
        io_sel = lat_io;
        rd_n   = !(strobe_ph && !lat_write);
        wr_n   = !(strobe_ph && lat_write);
        den_n  = !strobe_ph;
    end

endmodule

// File: rtl/muxbus_rcap.sv
`timescale 1ns/1ps
module muxbus_rcap
    import muxbus_pkg::*;
#(
    parameter int DW = 16,
    parameter int BW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  bus_state_e    state,
    input  logic          lat_write,
    input  logic [BW-1:0] ad_in,
    output logic [DW-1:0] rdata,
    output logic          done
);

    typedef struct packed {
        logic [DW-1:0] rdata;
        logic          done;
    } cap_t;

    cap_t cap_d, cap_q;

    always_comb begin
        cap_d      = cap_q;
        cap_d.done = (state == ST_T3);
        if ((state == ST_T3) && !lat_write) begin
            cap_d.rdata = ad_in[DW-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_q <= '{rdata: '0, done: 1'b0};
        end else begin
            cap_q <= cap_d;
        end
    end

    assign rdata = cap_q.rdata;
    assign done  = cap_q.done;

    assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cap_q.done |=> !cap_q.done);

    assert_done_in_t4_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cap_q.done |-> (state == ST_T4));

endmodule

// File: rtl/muxbus_master.sv
`timescale 1ns/1ps
module muxbus_master
    import muxbus_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 16,
    localparam int BW = (AW > DW) ? AW : DW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    input  logic          req_write,
    input  logic          req_io,
    output logic [DW-1:0] rsp_rdata,
    output logic          rsp_done,
    output logic [BW-1:0] bus_ad_out,
    output logic          bus_ad_oe,
    input  logic [BW-1:0] bus_ad_in,
    output logic          bus_ale,
    output logic          bus_dt_r,
    output logic          bus_io_sel,
    output logic          bus_rd_n,
    output logic          bus_wr_n,
    output logic          bus_den_n,
    input  logic          bus_ready
);

    bus_state_e    state;
    logic [AW-1:0] lat_addr;
    logic [DW-1:0] lat_wdata;
    logic          lat_write;
    logic          lat_io;

    muxbus_seq #(.AW(AW), .DW(DW)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .req_write (req_write),
        .req_io    (req_io),
        .ready     (bus_ready),
        .state     (state),
        .lat_addr  (lat_addr),
        .lat_wdata (lat_wdata),
        .lat_write (lat_write),
        .lat_io    (lat_io)
    );

    muxbus_pins #(.AW(AW), .DW(DW), .BW(BW)) u_pins (
        .state     (state),
        .lat_addr  (lat_addr),
        .lat_wdata (lat_wdata),
        .lat_write (lat_write),
        .lat_io    (lat_io),
        .ad_out    (bus_ad_out),
        .ad_oe     (bus_ad_oe),
        .ale       (bus_ale),
        .dt_r      (bus_dt_r),
        .io_sel    (bus_io_sel),
        .rd_n      (bus_rd_n),
        .wr_n      (bus_wr_n),
        .den_n     (bus_den_n)
    );

    muxbus_rcap #(.DW(DW), .BW(BW)) u_rcap (
        .clk       (clk),
        .rst_n     (rst_n),
        .state     (state),
        .lat_write (lat_write),
        .ad_in     (bus_ad_in),
        .rdata     (rsp_rdata),
        .done      (rsp_done)
    );

    assert_strobe_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(!bus_rd_n && !bus_wr_n));

    assert_read_release_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd_n |-> !bus_ad_oe);

    assert_ale_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ale |=> !bus_ale);

    assert_den_after_ale_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_den_n) |-> $past(bus_ale));

    assert_t4_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |-> (bus_rd_n && bus_wr_n && bus_den_n && !bus_ale));

endmodule

// File: tb/muxbus_master_bench.sv
`timescale 1ns/1ps
module muxbus_master_bench;

    localparam int AW = 16;
    localparam int DW = 16;
    localparam int BW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          req_write = 1'b0;
    logic          req_io = 1'b0;
    logic [DW-1:0] rsp_rdata;
    logic          rsp_done;
    logic [BW-1:0] bus_ad_out;
    logic          bus_ad_oe;
    logic [BW-1:0] bus_ad_in = '0;
    logic          bus_ale;
    logic          bus_dt_r;
    logic          bus_io_sel;
    logic          bus_rd_n;
    logic          bus_wr_n;
    logic          bus_den_n;
    logic          bus_ready = 1'b1;

    always #2.5 clk = ~clk;

    muxbus_master #(.AW(AW), .DW(DW)) u_muxbus_master (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .req_write  (req_write),
        .req_io     (req_io),
        .rsp_rdata  (rsp_rdata),
        .rsp_done   (rsp_done),
        .bus_ad_out (bus_ad_out),
        .bus_ad_oe  (bus_ad_oe),
        .bus_ad_in  (bus_ad_in),
        .bus_ale    (bus_ale),
        .bus_dt_r   (bus_dt_r),
        .bus_io_sel (bus_io_sel),
        .bus_rd_n   (bus_rd_n),
        .bus_wr_n   (bus_wr_n),
        .bus_den_n  (bus_den_n),
        .bus_ready  (bus_ready)
    );

    typedef struct {
        logic          wr;
        logic          io;
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
        int            waits;
        logic          junk;
    } xfer_t;

    xfer_t         exp_q[$];
    xfer_t         cur;
    int            checks = 0;
    int            errors = 0;
    logic          fin = 1'b0;
    logic          act = 1'b0;
    int            s = 0;
    logic [DW-1:0] last_rd = '0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act_v, input logic [31:0] exp_v);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act_v, exp_v);
        end
    endtask

    task automatic summary;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    // Driver: called at a falling edge; queues the expected transfer and pulses start.
    task automatic issue(input logic wr, input logic io, input logic [AW-1:0] a,
                         input logic [DW-1:0] d, input int w, input logic j);
        xfer_t it;
        it.wr = wr; it.io = io; it.addr = a; it.data = d; it.waits = w; it.junk = j;
        exp_q.push_back(it);
        start = 1'b1; req_write = wr; req_io = io; req_addr = a; req_wdata = d;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_t4;
        do @(negedge clk); while (!rsp_done);
    endtask

    // Monitor and target model: checks pins each cycle, drives ready and read data.
    always @(negedge clk) begin
        if (rst_n && !fin) begin
            if (bus_ale) begin
                if (act) chk(1'b0, "R9", "address strobe inside a running transfer", 32'd1, 32'd0);
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R9", "transfer started with none requested", 32'd1, 32'd0);
                    act = 1'b0;
                end else begin
                    cur = exp_q.pop_front();
                    act = 1'b1;
                    s = -1;
                    chk(bus_ad_oe == 1'b1, "R2", "T1 bus enable", 32'(bus_ad_oe), 32'd1);
                    chk(bus_ad_out == BW'(cur.addr), "R2", "T1 address", 32'(bus_ad_out), 32'(cur.addr));
                    chk(bus_dt_r == cur.wr, "R2", "T1 direction", 32'(bus_dt_r), 32'(cur.wr));
                    chk(bus_io_sel == cur.io, "R2", "T1 io select", 32'(bus_io_sel), 32'(cur.io));
                    chk(bus_den_n && bus_rd_n && bus_wr_n, "R5", "T1 strobes idle",
                        32'({bus_den_n, bus_rd_n, bus_wr_n}), 32'h7);
                    bus_ready = cur.junk;
                    bus_ad_in = ~BW'(cur.data);
                end
            end else if (act) begin
                s++;
                if (s <= cur.waits + 1) begin
                    string tag;
                    if (s == 0) tag = cur.wr ? "R4" : "R3";
                    else if (s <= cur.waits) tag = "R6";
                    else tag = "R10";
                    chk(bus_rd_n == cur.wr && bus_wr_n == !cur.wr, tag, "strobe levels",
                        32'({bus_rd_n, bus_wr_n}), 32'({cur.wr, !cur.wr}));
                    chk(bus_den_n == 1'b0, "R5", "transceiver enable", 32'(bus_den_n), 32'd0);
                    chk(rsp_done == 1'b0, "R7", "done before T4", 32'(rsp_done), 32'd0);
                    chk(bus_dt_r == cur.wr && bus_io_sel == cur.io, "R2", "direction/select hold",
                        32'({bus_dt_r, bus_io_sel}), 32'({cur.wr, cur.io}));
                    if (cur.wr) begin
                        chk(bus_ad_oe && bus_ad_out == BW'(cur.data), "R4", "write data on bus",
                            32'(bus_ad_out), 32'(cur.data));
                    end else begin
                        chk(bus_ad_oe == 1'b0, "R3", "bus released in read", 32'(bus_ad_oe), 32'd0);
                    end
                    if (s <= cur.waits) bus_ready = (s == cur.waits);
                    else bus_ready = cur.junk;
                    bus_ad_in = (s == cur.waits + 1) ? BW'(cur.data) : ~BW'(cur.data);
                end else begin
                    chk(rsp_done == 1'b1, "R7", "done in T4", 32'(rsp_done), 32'd1);
                    chk(bus_rd_n && bus_wr_n && bus_den_n && !bus_ale, "R8", "T4 strobes inactive",
                        32'({bus_rd_n, bus_wr_n, bus_den_n, bus_ale}), 32'hE);
                    if (cur.wr) begin
                        chk(bus_ad_oe && bus_ad_out == BW'(cur.data), "R8", "write data held in T4",
                            32'(bus_ad_out), 32'(cur.data));
                        chk(rsp_rdata == last_rd, "R7", "read data kept over write",
                            32'(rsp_rdata), 32'(last_rd));
                    end else begin
                        chk(bus_ad_oe == 1'b0, "R3", "bus released in T4", 32'(bus_ad_oe), 32'd0);
                        chk(rsp_rdata == cur.data, "R7", "captured read data",
                            32'(rsp_rdata), 32'(cur.data));
                        last_rd = cur.data;
                    end
                    act = 1'b0;
                    bus_ready = cur.junk;
                    bus_ad_in = ~BW'(cur.data);
                end
            end else begin
                chk(!rsp_done && !bus_ad_oe && !bus_ale && bus_rd_n && bus_wr_n && bus_den_n,
                    "R1", "idle outputs",
                    32'({rsp_done, bus_ad_oe, bus_ale, bus_rd_n, bus_wr_n, bus_den_n}), 32'h7);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!fin) begin
            fin = 1'b1;
            errors++;
            $display("FAIL watchdog: actual hung expected finished");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(bus_rd_n && bus_wr_n && bus_den_n && !bus_ale && !bus_ad_oe && !rsp_done, "R1",
            "outputs in reset", 32'({bus_rd_n, bus_wr_n, bus_den_n, bus_ale, bus_ad_oe, rsp_done}), 32'h38);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R3 R7: memory read, no waits, ready high outside sampling
        issue(1'b0, 1'b0, 16'h1234, 16'hBEEF, 0, 1'b1);
        wait_t4();
        repeat (2) @(negedge clk);

        // R4 R6 R8: I/O write with two waits, ready low outside sampling
        issue(1'b1, 1'b1, 16'h00F0, 16'hA5C3, 2, 1'b0);
        wait_t4();
        repeat (2) @(negedge clk);

        // R6 R10: I/O read with three waits, ready low in T1/T3/T4
        issue(1'b0, 1'b1, 16'h8001, 16'h3C5A, 3, 1'b0);
        wait_t4();
        @(negedge clk);

        // R9: back-to-back write then read with no idle gap
        issue(1'b1, 1'b0, 16'h4000, 16'h1111, 0, 1'b1);
        wait_t4();
        issue(1'b0, 1'b0, 16'h4002, 16'h2222, 1, 1'b0);
        chk(bus_ale == 1'b1, "R9", "next T1 directly after T4", 32'(bus_ale), 32'd1);
        wait_t4();
        repeat (2) @(negedge clk);

        // R9: start held during T1 and T2 of a long write is ignored
        issue(1'b1, 1'b0, 16'h7777, 16'h5A5A, 4, 1'b0);
        start = 1'b1; req_addr = 16'hDEAD; req_wdata = 16'h0BAD; req_write = 1'b0;
        @(negedge clk);
        @(negedge clk);
        start = 1'b0;
        wait_t4();
        repeat (4) @(negedge clk);

        // R6: long stretch
        issue(1'b0, 1'b0, 16'hFFFE, 16'h9876, 20, 1'b1);
        wait_t4();
        repeat (3) @(negedge clk);
        chk(rsp_rdata == 16'h9876, "R7", "read data held after done", 32'(rsp_rdata), 32'h9876);

        chk(exp_q.size() == 0 && !act, "R9", "every requested transfer ran",
            32'(exp_q.size()), 32'd0);
        fin = 1'b1;
        summary();
        $finish;
    end

endmodule